// File: doc/BRIEF.md
# Task Pointer Mailbox with Acknowledge Handshake

This block is a one-entry mailbox through which a host processor hands a task-control-block address to a peer processor. The host drives I/O pulse commands that carry a device code and three pulse bits. When the device code matches the block's own code, the pulse bits act together in one command. They can test the acknowledge flag and answer with a skip, clear that flag, and load the pointer register from the host accumulator. The stored pointer always keeps only the address bits, so the top bit of the host word is stored as zero.

On the peer side the block presents the stored pointer and a one-cycle notification that a new pointer has been written. It also accepts a strobe that reports the peer has read the pointer. The strobe sets the acknowledge flag. The host clears the flag when it posts a new request and polls it with the skip test. The flag comes out of reset set, which means no request is outstanding.

Top module: `tcb_mailbox`

## Requirements
- R1: After reset the acknowledge flag is 1, `ptr_out` is 0 and `ptr_new` is 0; a skip test issued as the very first command answers with `skip_out` = 1.
- R2: During a matching command with pulse bit 0 set, `skip_out` is 1 in that same cycle exactly when the acknowledge flag is 1; in every other case `skip_out` is 0.
- R3: A matching command with pulse bit 1 set clears the acknowledge flag from the next clock edge on, unless R7 applies.
- R4: A matching command with pulse bit 2 set loads `ptr_out` at the next edge with `acc_in` ANDed with a mask of ADDR_W low ones, so bit 17 of the default 18-bit word is stored as 0.
- R5: `ptr_new` is 1 for exactly the one cycle after the edge that accepted a load, and it changes in the same cycle as `ptr_out`.
- R6: A cycle with `peer_rd_ack` high sets the acknowledge flag to 1 at the next edge.
- R7: When `peer_rd_ack` and a matching clear command occur in the same cycle, the flag ends up set.
- R8: Pulse bits combine in one command: the skip answer reflects the flag as it was before a clear in that command, and a load in that command happens as well.
- R9: A command with `iot_valid` low or with `iot_dev` different from DEV_CODE (default octal 60) changes neither the flag nor the pointer, raises no `ptr_new` and gives `skip_out` = 0.
- R10: Between loads `ptr_out` holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| iot_valid | input | 1 | Host I/O command present this cycle |
| iot_dev | input | DEV_W | Device code carried by the command |
| iot_pulse | input | 3 | Pulse bits: 0 skip test, 1 clear flag, 2 load pointer |
| acc_in | input | WORD_W | Host accumulator value |
| skip_out | output | 1 | Skip response, combinational |
| ptr_out | output | WORD_W | Stored task-control-block pointer |
| ptr_new | output | 1 | One-cycle notice that a pointer was loaded |
| peer_rd_ack | input | 1 | Peer strobe: pointer has been read |

## Verification
A wrong acknowledge flag shows up only through the skip answer, so the bench follows each command with a skip probe in the next cycle. A stuck, inverted or wrongly prioritised flag is then visible one cycle after the command that disturbed it. A wrong pointer or mask appears at `ptr_out` right after the loading edge. A stretched or missing notice shows up as `ptr_new` being wrong in that cycle or in the probe cycle. The sweep covers every pulse combination, both starting flag values, the peer strobe on and off, and a matching code, a foreign code or no command at all.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
   localparam int PULSE_W = 3;
   localparam int PB_SKIP = 0;
   localparam int PB_CLR  = 1;
   localparam int PB_LOAD = 2;

   typedef struct packed {
      logic test;
      logic clr;
      logic load;
   } mbx_cmd_t;
endpackage

// File: rtl/mbx_cmd_decode.sv
module mbx_cmd_decode
   import mbx_pkg::*;
#(
   parameter int DEV_W    = 6,
   parameter int DEV_CODE = 6'o60
) (
   input  logic               valid_i,
   input  logic [DEV_W-1:0]   dev_i,
   input  logic [PULSE_W-1:0] pulse_i,
   output mbx_cmd_t           cmd_o
);
   localparam logic [DEV_W-1:0] MY_CODE = DEV_W'(DEV_CODE);

   logic hit;

   always_comb begin
      hit        = valid_i && (dev_i == MY_CODE);
      cmd_o.test = hit && pulse_i[PB_SKIP];
      cmd_o.clr  = hit && pulse_i[PB_CLR];
      cmd_o.load = hit && pulse_i[PB_LOAD];
   end
endmodule

// File: rtl/mbx_ack_flag.sv
module mbx_ack_flag (
   input  logic clk,
   input  logic rst_n,
   input  logic set_i,
   input  logic clr_i,
   output logic ack_o
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         ack_o <= 1'b1;
      else if (set_i)
         ack_o <= 1'b1;
      else if (clr_i)
         ack_o <= 1'b0;
   end

   p_peer_sets_r6: assert property (@(posedge clk) disable iff (!rst_n)
      set_i |=> ack_o);
   p_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_i && !set_i) |=> !ack_o);
   p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr_i && !set_i) |=> $stable(ack_o));
endmodule

// File: rtl/mbx_ptr_reg.sv
module mbx_ptr_reg #(
   parameter int WORD_W = 18,
   parameter int ADDR_W = 17
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load_i,
   input  logic [WORD_W-1:0] acc_i,
   output logic [WORD_W-1:0] ptr_o,
   output logic              new_o
);
   logic [WORD_W-1:0] keep_mask;

   generate
      if (ADDR_W < WORD_W) begin : g_narrow
         assign keep_mask = {{(WORD_W-ADDR_W){1'b0}}, {ADDR_W{1'b1}}};
      end else begin : g_full
         assign keep_mask = {WORD_W{1'b1}};
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ptr_o <= '0;
         new_o <= 1'b0;
      end else begin
         new_o <= load_i;
         if (load_i)
            ptr_o <= acc_i & keep_mask;
      end
   end

   p_load_value_r4: assert property (@(posedge clk) disable iff (!rst_n)
      load_i |=> (ptr_o[ADDR_W-1:0] == $past(acc_i[ADDR_W-1:0])));
   p_notice_after_load_r5: assert property (@(posedge clk) disable iff (!rst_n)
      load_i |=> new_o);
   p_notice_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !load_i |=> !new_o);
   p_ptr_holds_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !load_i |=> $stable(ptr_o));
endmodule

// File: rtl/tcb_mailbox.sv
module tcb_mailbox
   import mbx_pkg::*;
#(
   parameter int WORD_W   = 18,
   parameter int ADDR_W   = 17,
   parameter int DEV_W    = 6,
   parameter int DEV_CODE = 6'o60
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               iot_valid,
   input  logic [DEV_W-1:0]   iot_dev,
   input  logic [PULSE_W-1:0] iot_pulse,
   input  logic [WORD_W-1:0]  acc_in,
   output logic               skip_out,
   output logic [WORD_W-1:0]  ptr_out,
   output logic               ptr_new,
   input  logic               peer_rd_ack
);
   initial begin
      assert (ADDR_W >= 1 && ADDR_W <= WORD_W)
         else $error("tcb_mailbox: ADDR_W must lie in 1..WORD_W");
      assert (DEV_W >= 1 && DEV_CODE >= 0 && DEV_CODE < (1 << DEV_W))
         else $error("tcb_mailbox: DEV_CODE does not fit DEV_W");
   end

   mbx_cmd_t cmd;
   logic     ack_w;

   mbx_cmd_decode #(.DEV_W(DEV_W), .DEV_CODE(DEV_CODE)) u_dec (
      .valid_i (iot_valid),
      .dev_i   (iot_dev),
      .pulse_i (iot_pulse),
      .cmd_o   (cmd)
   );

   mbx_ack_flag u_ack (
      .clk   (clk),
      .rst_n (rst_n),
      .set_i (peer_rd_ack),
      .clr_i (cmd.clr),
      .ack_o (ack_w)
   );

   mbx_ptr_reg #(.WORD_W(WORD_W), .ADDR_W(ADDR_W)) u_ptr (
      .clk    (clk),
      .rst_n  (rst_n),
      .load_i (cmd.load),
      .acc_i  (acc_in),
      .ptr_o  (ptr_out),
      .new_o  (ptr_new)
   );

   // skip samples the flag before any clear in the same command (R8)
   assign skip_out = cmd.test & ack_w;

   p_skip_needs_ack_r2: assert property (@(posedge clk) disable iff (!rst_n)
      skip_out |-> ack_w);
   p_idle_no_skip_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !iot_valid |-> !skip_out);
   p_set_beats_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (peer_rd_ack && cmd.clr) |=> ack_w);
endmodule

// File: tb/tb_tcb_mailbox.sv
module tb_tcb_mailbox;
   localparam int WORD_W = 18;
   localparam int ADDR_W = 17;
   localparam int DEV_W  = 6;
   localparam int DEV_CODE = 6'o60;
   localparam logic [WORD_W-1:0] MASK = (18'd1 << ADDR_W) - 18'd1;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              iot_valid = 1'b0;
   logic [DEV_W-1:0]  iot_dev = '0;
   logic [2:0]        iot_pulse = '0;
   logic [WORD_W-1:0] acc_in = '0;
   logic              skip_out;
   logic [WORD_W-1:0] ptr_out;
   logic              ptr_new;
   logic              peer_rd_ack = 1'b0;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   tcb_mailbox #(.WORD_W(WORD_W), .ADDR_W(ADDR_W), .DEV_W(DEV_W), .DEV_CODE(DEV_CODE)) dut (
      .clk(clk), .rst_n(rst_n), .iot_valid(iot_valid), .iot_dev(iot_dev),
      .iot_pulse(iot_pulse), .acc_in(acc_in), .skip_out(skip_out),
      .ptr_out(ptr_out), .ptr_new(ptr_new), .peer_rd_ack(peer_rd_ack)
   );

   task automatic check(input string tag, input logic [WORD_W-1:0] act,
                        input logic [WORD_W-1:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // called at a falling edge; returns at the next falling edge
   task automatic step(input logic v, input logic [DEV_W-1:0] d, input logic [2:0] p,
                       input logic [WORD_W-1:0] a, input logic peer, output logic sk);
      iot_valid = v; iot_dev = d; iot_pulse = p; acc_in = a; peer_rd_ack = peer;
      #1 sk = skip_out;
      @(negedge clk);
      iot_valid = 1'b0; iot_pulse = '0; peer_rd_ack = 1'b0;
   endtask

   initial begin
      #200000;
      if (!done) begin
         failures++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      logic sk;
      logic m_ack;
      logic [WORD_W-1:0] m_ptr;
      logic [WORD_W-1:0] a;
      logic hit;
      logic [DEV_W-1:0] d;
      string tg;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      check("R1 ptr_out", ptr_out, '0);
      check("R1 ptr_new", {17'd0, ptr_new}, '0);
      step(1'b1, DEV_W'(DEV_CODE), 3'b001, '0, 1'b0, sk);
      check("R1 skip", {17'd0, sk}, 18'd1);
      m_ack = 1'b1; m_ptr = '0;
      for (int prep = 0; prep < 2; prep++)
         for (int sel = 0; sel < 3; sel++)
            for (int p = 0; p < 8; p++)
               for (int peer = 0; peer < 2; peer++) begin
                  int it;
                  it = ((prep * 3 + sel) * 8 + p) * 2 + peer;
                  // prepare flag
                  if (prep == 1) step(1'b0, '0, 3'b000, '0, 1'b1, sk);
                  else           step(1'b1, DEV_W'(DEV_CODE), 3'b010, '0, 1'b0, sk);
                  m_ack = (prep == 1);
                  a = {1'b1, 17'(it * 4093 + 5)};
                  d = (sel == 1) ? DEV_W'(DEV_CODE + 1) : DEV_W'(DEV_CODE);
                  hit = (sel == 0);
                  step(sel != 2, d, 3'(p), a, peer[0], sk);
                  tg = !hit ? "R9 skip" : ((p & 3) == 3) ? "R8 skip" : "R2 skip";
                  check(tg, {17'd0, sk}, {17'd0, hit & p[0] & m_ack});
                  if (hit && p[2]) m_ptr = a & MASK;
                  tg = !hit ? "R9 ptr" : p[2] ? "R4 ptr" : "R10 ptr";
                  check(tg, ptr_out, m_ptr);
                  check(!hit ? "R9 new" : "R5 new", {17'd0, ptr_new}, {17'd0, hit & p[2]});
                  if (peer == 1) m_ack = 1'b1;
                  else if (hit && p[1]) m_ack = 1'b0;
                  tg = (peer == 1 && hit && p[1]) ? "R7 ack" : (peer == 1) ? "R6 ack" :
                       !hit ? "R9 ack" : "R3 ack";
                  step(1'b1, DEV_W'(DEV_CODE), 3'b001, '0, 1'b0, sk);
                  check(tg, {17'd0, sk}, {17'd0, m_ack});
                  check("R5 single", {17'd0, ptr_new}, '0);
                  check("R10 hold", ptr_out, m_ptr);
               end
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule